// File: doc/BRIEF.md
# Instruction Cycle Timing Sequencer

This block produces the instruction-cycle timing for a small accumulator-style microcontroller core. It counts the oscillator clock into instruction cycles of four phases, Q1 to Q4, and drives one strobe for each phase. It pulses a cycle-end marker in the last phase and enables the fetch of the next word there.

The instruction decoder reports three conditions: a conditional test came out true, the instruction writes the program counter, or the instruction is a table read or write. The sequencer samples these flags at the cycle boundary. If any flag is set, the instruction is stretched to two cycles. In the second cycle the sequencer raises a forced-NOP flag, and the execute stage then throws away the word fetched for that slot.

A stretched cycle can never be stretched again. A synchronous reset also opens with one forced-NOP cycle, so the first word fetched after reset is not executed.

Top module: `icyc_sequencer`

## Requirements
- R1: The phase strobes `phase_o` are one-hot, with bit 0 for Q1 and bit 3 for Q4. They advance one position on every clock, from Q1 to Q2 to Q3 to Q4 and back to Q1. An instruction cycle is therefore exactly four clock periods, which is 160 ns at a 25 MHz oscillator.
- R2: `cycle_end_o` and `fetch_en_o` are high during Q4 of every cycle and low during Q1, Q2 and Q3.
- R3: The stall flags are sampled only at the clock edge that ends Q4. A flag that is raised and dropped again before Q4 has no effect on the next cycle.
- R4: If `cond_true_i`, `pc_write_i` or `table_op_i` is high at the end of a normal cycle, `force_nop_o` is high for all four phases of the next cycle. The instruction then takes eight clocks, which is 320 ns at 25 MHz.
- R5: If no stall flag is high at the end of a normal cycle, `force_nop_o` is low in the next cycle, and the instruction completes in one cycle.
- R6: Stall flags presented during a forced-NOP cycle are ignored, so the cycle after it is a normal cycle (`force_nop_o` low).
- R7: While `rst` is high at a clock edge, the sequencer goes to Q1 with `force_nop_o` high. This applies even when reset arrives in the middle of a cycle. After release, the first cycle is a forced-NOP cycle and the one after it is normal.
- R8: `force_nop_o` changes only at the edge that ends Q4, or under reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous reset, active high |
| cond_true_i | input | 1 | Decoder: conditional test true |
| pc_write_i | input | 1 | Decoder: instruction modifies the program counter |
| table_op_i | input | 1 | Decoder: table read or table write |
| phase_o | output | 4 | One-hot phase strobes, bit 0 = Q1 |
| cycle_end_o | output | 1 | High in Q4, marks the cycle boundary |
| fetch_en_o | output | 1 | Fetch enable for the next word, high in Q4 |
| force_nop_o | output | 1 | Current cycle executes as a NOP |

## Verification
The bench runs each of the three stall causes, alone and together, back to back. A design that chained extensions would show two forced-NOP cycles in a row, and a design that ignored one cause would let that instruction finish in a single cycle. A flag pulse that ends before Q4 is used to catch sampling in the wrong phase, and the gaps between cycle-end pulses are measured to catch a ring with the wrong length. A reset in the middle of a cycle must restart at Q1 with a NOP, and the stall flags raised in that NOP cycle must not extend it.

// File: rtl/icyc_pkg.sv
package icyc_pkg;

    localparam int unsigned NUM_PHASES = 4;

    // Stall causes reported by the decoder for the current instruction
    typedef struct packed {
        logic table_op;
        logic pc_write;
        logic cond_true;
    } stall_req_t;

    typedef struct packed {
        logic nop;
    } extend_state_t;

endpackage

// File: rtl/icyc_phase_ring.sv
module icyc_phase_ring #(
    parameter int unsigned PHASES = icyc_pkg::NUM_PHASES
) (
    input  logic              clk,
    input  logic              rst,
    output logic [PHASES-1:0] ring_o,
    output logic              last_phase_o
);

    typedef struct packed {
        logic [PHASES-1:0] ring;
    } ring_state_t;

    ring_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.ring = {st_q.ring[PHASES-2:0], st_q.ring[PHASES-1]};
        if (rst) begin
            st_d.ring = {{(PHASES-1){1'b0}}, 1'b1};
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign ring_o       = st_q.ring;
    assign last_phase_o = st_q.ring[PHASES-1];

    AST_RING_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $countones(st_q.ring) == 1) else $error("phase ring not one-hot"); // R1

    AST_RING_STEP: assert property (@(posedge clk) disable iff (rst)
        st_q.ring[0] |=> st_q.ring[1]) else $error("Q1 not followed by Q2"); // R1

    AST_RING_WRAP: assert property (@(posedge clk) disable iff (rst)
        st_q.ring[PHASES-1] |=> st_q.ring[0]) else $error("Q4 not followed by Q1"); // R1

endmodule

// File: rtl/icyc_extend_ctrl.sv
module icyc_extend_ctrl (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   boundary_i,
    input  icyc_pkg::stall_req_t   req_i,
    output logic                   force_nop_o
);

    icyc_pkg::extend_state_t st_d, st_q;
    logic any_req;

    assign any_req = |req_i;

    always_comb begin
        st_d = st_q;
        if (boundary_i) begin
            // Only a normal cycle may request a stretch; a NOP slot never chains
            st_d.nop = any_req && !st_q.nop;
        end
        if (rst) begin
            st_d.nop = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign force_nop_o = st_q.nop;

    AST_STALL_EXTENDS: assert property (@(posedge clk) disable iff (rst)
        (boundary_i && !st_q.nop && any_req) |=> st_q.nop) else $error("stall lost"); // R4

    AST_PLAIN_SINGLE: assert property (@(posedge clk) disable iff (rst)
        (boundary_i && !st_q.nop && !any_req) |=> !st_q.nop) else $error("spurious NOP"); // R5

    AST_NO_CHAIN: assert property (@(posedge clk) disable iff (rst)
        (boundary_i && st_q.nop) |=> !st_q.nop) else $error("NOP chained"); // R6

    AST_BOUNDARY_ONLY: assert property (@(posedge clk) disable iff (rst)
        !boundary_i |=> $stable(st_q.nop)) else $error("NOP changed mid-cycle"); // R8

endmodule

// File: rtl/icyc_sequencer.sv
module icyc_sequencer #(
    parameter int unsigned PHASES = icyc_pkg::NUM_PHASES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cond_true_i,
    input  logic              pc_write_i,
    input  logic              table_op_i,
    output logic [PHASES-1:0] phase_o,
    output logic              cycle_end_o,
    output logic              fetch_en_o,
    output logic              force_nop_o
);

    icyc_pkg::stall_req_t req;
    logic                 last_phase;

    always_comb begin
        req           = '0;
        req.cond_true = cond_true_i;
        req.pc_write  = pc_write_i;
        req.table_op  = table_op_i;
    end

    icyc_phase_ring #(.PHASES(PHASES)) u_ring (
        .clk          (clk),
        .rst          (rst),
        .ring_o       (phase_o),
        .last_phase_o (last_phase)
    );

    icyc_extend_ctrl u_extend (
        .clk         (clk),
        .rst         (rst),
        .boundary_i  (last_phase),
        .req_i       (req),
        .force_nop_o (force_nop_o)
    );

    assign cycle_end_o = last_phase;
    assign fetch_en_o  = last_phase;

    AST_END_THEN_Q1: assert property (@(posedge clk) disable iff (rst)
        cycle_end_o |=> (phase_o[0] && !cycle_end_o)) else $error("cycle end misplaced"); // R2

    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (phase_o[0] && force_nop_o)) else $error("reset state wrong"); // R7

endmodule

// File: tb/tb_icyc_sequencer.sv
module tb_icyc_sequencer;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cond_true_i = 1'b0;
    logic       pc_write_i = 1'b0;
    logic       table_op_i = 1'b0;
    logic [3:0] phase_o;
    logic       cycle_end_o, fetch_en_o, force_nop_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    icyc_sequencer dut (
        .clk(clk), .rst(rst),
        .cond_true_i(cond_true_i), .pc_write_i(pc_write_i), .table_op_i(table_op_i),
        .phase_o(phase_o), .cycle_end_o(cycle_end_o),
        .fetch_en_o(fetch_en_o), .force_nop_o(force_nop_o)
    );

    // {expected force_nop in this cycle, flags {table, pc, cond} driven in it}
    localparam logic [3:0] VEC [12] = '{
        4'b1_111, 4'b0_000, 4'b0_001, 4'b1_001,
        4'b0_010, 4'b1_000, 4'b0_100, 4'b1_100,
        4'b0_000, 4'b0_110, 4'b1_000, 4'b0_000
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic set_flags(input logic [2:0] f);
        table_op_i  = f[2];
        pc_write_i  = f[1];
        cond_true_i = f[0];
    endtask

    initial begin
        #(8 * 20000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int gap;
        repeat (3) @(negedge clk);
        chk("R7 reset phase", phase_o, 1);
        chk("R7 reset nop", force_nop_o, 1);
        rst = 1'b0;

        // Vector walk: each entry is one instruction cycle, starting in Q1
        for (int i = 0; i < 12; i++) begin
            chk("R4 R5 R6 vector nop", force_nop_o, VEC[i][3]);
            chk("R1 Q1 strobe", phase_o, 1);
            chk("R2 no end in Q1", cycle_end_o, 0);
            set_flags(VEC[i][2:0]);
            @(negedge clk);
            chk("R1 Q2 strobe", phase_o, 2);
            chk("R8 nop steady Q2", force_nop_o, VEC[i][3]);
            @(negedge clk);
            chk("R1 Q3 strobe", phase_o, 4);
            @(negedge clk);
            chk("R1 Q4 strobe", phase_o, 8);
            chk("R2 cycle end in Q4", cycle_end_o, 1);
            chk("R2 fetch in Q4", fetch_en_o, 1);
            chk("R8 nop steady Q4", force_nop_o, VEC[i][3]);
            @(negedge clk);
        end
        set_flags(3'b000);

        // R3: pulse ending before Q4 is not sampled
        chk("R5 normal cycle", force_nop_o, 0);
        cond_true_i = 1'b1;
        @(negedge clk);
        @(negedge clk);
        cond_true_i = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R3 early pulse ignored", force_nop_o, 0);

        // R1: cycle-end spacing of four clocks
        while (!cycle_end_o) @(negedge clk);
        gap = 0;
        do begin
            @(negedge clk);
            gap++;
        end while (!cycle_end_o);
        chk("R1 cycle length", gap, 4);
        @(negedge clk);

        // R4: program-counter write stretches to eight clocks
        pc_write_i = 1'b1;
        repeat (4) @(negedge clk);
        pc_write_i = 1'b0;
        chk("R4 second cycle nop", force_nop_o, 1);
        repeat (4) @(negedge clk);
        chk("R4 done after eight clocks", force_nop_o, 0);

        // R7: reset in Q3 restarts at Q1 with a NOP cycle
        @(negedge clk);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk("R7 mid-cycle reset phase", phase_o, 1);
        chk("R7 mid-cycle reset nop", force_nop_o, 1);
        rst = 1'b0;
        table_op_i = 1'b1;
        repeat (4) @(negedge clk);
        table_op_i = 1'b0;
        chk("R6 R7 reset NOP does not chain", force_nop_o, 0);
        chk("R1 back in Q1", phase_o, 1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule